// File: doc/BRIEF.md
# Parallel-ATA programmed-I/O cycle sequencer

This block turns a single host request into one complete programmed-I/O bus cycle on a parallel-ATA device interface. The request carries a 5-bit register select, a direction, a 16-bit write value and a width flag. The width flag picks between an 8-bit taskfile register access and a 16-bit data-port access. The block drives the two chip selects, the 3-bit device address and the active-low read and write strobes, and it runs each cycle through three phases: address setup, strobe active and recovery.

All phase lengths are counted in clock ticks and are set by programmable 8-bit values. A zero value counts as one tick. Register cycles and data cycles each have their own active, recovery and full-cycle values, and both share one setup value. The device can stretch the active phase by holding its ready line low. This stretch is bounded by a fixed cap, and a cycle that hits the cap sets a sticky timeout flag. The recovery phase is long enough to meet both the minimum recovery and the total cycle length. On a write, a small hold count keeps the data bus driven for a few ticks after the write strobe rises.

Top module: `pata_pio_seq`

## Requirements
- R1: After reset, and whenever no cycle is running, ata_cs0n, ata_cs1n, ata_diorn and ata_diown are high. In the same state dd_oe and ack are low and ata_da is 0. After reset timeout_flag is 0.
- R2: req_sel is decoded as address = req_sel[4:2], CS1 level = req_sel[1] and CS0 level = req_sel[0]. These values are driven on ata_da, ata_cs1n and ata_cs0n unchanged from the first setup tick to the last recovery tick. Examples: the command-block status register is 5'd30 (address 7, cs1n=1, cs0n=0), and the control register is 5'd25 (address 6, cs1n=0, cs0n=1).
- R3: A cycle starts with max(t_setup,1) ticks in which the address and selects are driven and both strobes are high. Then exactly one strobe goes low: ata_diorn when req_wr=0, or ata_diown when req_wr=1.
- R4: The strobe stays low for max(t_act,1) ticks when IORDY monitoring is off or ata_iordy is high at the programmed end. t_act is t_act8 when req_reg8=1 and t_act16 when req_reg8=0.
- R5: When iordy_en=1 and ata_iordy is low at the end of the programmed active time, the strobe stays low until the first tick in which ata_iordy is sampled high. The total strobe-low time never exceeds ACT_MAX ticks (default 257). A low ata_iordy before the programmed end has no effect.
- R6: If ata_iordy is still low in strobe-low tick ACT_MAX, the strobe is released anyway, timeout_flag is set, and the cycle finishes normally with ack. timeout_flag stays set until reset.
- R7: After the strobe rises, the recovery phase lasts max(max(t_rec,1), t_cyc − actual active ticks) ticks. Each value is taken from the set that req_reg8 selects, and t_cyc=0 counts as 1.
- R8: On a read, rdata takes the value of dd_in that was present in the last strobe-low tick, which is the sample taken at the edge where ata_diorn rises. rdata holds that value while ack is high.
- R9: On a write, dd_out equals req_wdata and dd_oe is high in every ata_diown-low tick. dd_oe then stays high for min(wr_hold, recovery ticks) ticks after the strobe rises. dd_oe is never high on a read.
- R10: ack is high for exactly one tick, in the tick after the last recovery tick, with all pins back at their idle levels. req is accepted only while idle, and that includes the ack tick. A req pulse during a running cycle starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start-cycle pulse, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_reg8 | input | 1 | 1 = 8-bit register timing set, 0 = 16-bit data set |
| req_sel | input | 5 | {address[2:0], cs1n, cs0n} |
| req_wdata | input | 16 | Write value |
| iordy_en | input | 1 | Enable active-phase stretching on ata_iordy |
| t_setup | input | 8 | Setup ticks (shared) |
| t_act8 | input | 8 | Register-cycle active ticks |
| t_rec8 | input | 8 | Register-cycle minimum recovery ticks |
| t_cyc8 | input | 8 | Register-cycle total ticks |
| t_act16 | input | 8 | Data-cycle active ticks |
| t_rec16 | input | 8 | Data-cycle minimum recovery ticks |
| t_cyc16 | input | 8 | Data-cycle total ticks |
| wr_hold | input | 2 | Write-data hold ticks after strobe rise |
| ata_cs0n | output | 1 | Chip select 0, active low |
| ata_cs1n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device address |
| ata_diorn | output | 1 | Read strobe, active low |
| ata_diown | output | 1 | Write strobe, active low |
| ata_iordy | input | 1 | Device ready |
| dd_in | input | 16 | Data bus input |
| dd_out | output | 16 | Data bus output |
| dd_oe | output | 1 | Data bus output enable |
| ack | output | 1 | One-tick completion pulse |
| rdata | output | 16 | Captured read data |
| timeout_flag | output | 1 | Sticky ready-timeout flag |

## Verification
Two functions can land in the same tick: the completion pulse of one cycle and the acceptance of the next request. The bench provokes this by raising req in exactly the tick where ack is high. It then judges the result against the scoreboard. The first cycle must report its own read data. The second cycle must start setup in the very next tick, with its own select, direction and phase lengths. A second collision is also tested: a device that holds ready low past the cap. In that case the forced strobe release and the timeout flag must arrive in the cap tick, and the phase counts must still add up.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;
  localparam int PIO_TW = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACT, ST_REC} pio_state_e;

  typedef struct packed {
    logic [PIO_TW-1:0] act;
    logic [PIO_TW-1:0] rec;
    logic [PIO_TW-1:0] cyc;
  } pio_tset_t;

  function automatic logic [PIO_TW-1:0] at_least_one(input logic [PIO_TW-1:0] v);
    return (v == '0) ? PIO_TW'(1) : v;
  endfunction
endpackage

// File: rtl/pata_timing_sel.sv
module pata_timing_sel
  import pata_pio_pkg::*;
(
  input  logic              reg8,
  input  logic [PIO_TW-1:0] act8,
  input  logic [PIO_TW-1:0] rec8,
  input  logic [PIO_TW-1:0] cyc8,
  input  logic [PIO_TW-1:0] act16,
  input  logic [PIO_TW-1:0] rec16,
  input  logic [PIO_TW-1:0] cyc16,
  output pio_tset_t         tset
);
  always_comb begin
    tset.act = at_least_one(reg8 ? act8 : act16);
    tset.rec = at_least_one(reg8 ? rec8 : rec16);
    tset.cyc = at_least_one(reg8 ? cyc8 : cyc16);
  end
endmodule

// File: rtl/pata_sel_decode.sv
module pata_sel_decode #(
  parameter int DA_W = 3
) (
  input  logic [DA_W+1:0] sel,
  output logic [DA_W-1:0] da,
  output logic            cs1n,
  output logic            cs0n
);
  assign da   = sel[DA_W+1:2];
  assign cs1n = sel[1];
  assign cs0n = sel[0];
endmodule

// File: rtl/pata_recov_calc.sv
module pata_recov_calc #(
  parameter int TW = 8,
  parameter int AW = 9
) (
  input  logic [TW-1:0] rec,
  input  logic [TW-1:0] cyc,
  input  logic [AW-1:0] act_len,
  output logic [TW-1:0] rec_len
);
  localparam int MW = ((AW > TW) ? AW : TW) + 1;

  logic [MW-1:0] cyc_x, act_x, gap;

  always_comb begin
    cyc_x   = MW'(cyc);
    act_x   = MW'(act_len);
    gap     = (cyc_x > act_x) ? (cyc_x - act_x) : '0;
    rec_len = (gap > MW'(rec)) ? TW'(gap) : rec;
  end
endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
  import pata_pio_pkg::*;
#(
  parameter int ACT_MAX = 257,
  parameter int DW      = 16,
  parameter int DA_W    = 3,
  parameter int HOLD_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_reg8,
  input  logic [DA_W+1:0]   req_sel,
  input  logic [DW-1:0]     req_wdata,
  input  logic              iordy_en,
  input  logic [PIO_TW-1:0] t_setup,
  input  logic [PIO_TW-1:0] t_act8,
  input  logic [PIO_TW-1:0] t_rec8,
  input  logic [PIO_TW-1:0] t_cyc8,
  input  logic [PIO_TW-1:0] t_act16,
  input  logic [PIO_TW-1:0] t_rec16,
  input  logic [PIO_TW-1:0] t_cyc16,
  input  logic [HOLD_W-1:0] wr_hold,
  output logic              ata_cs0n,
  output logic              ata_cs1n,
  output logic [DA_W-1:0]   ata_da,
  output logic              ata_diorn,
  output logic              ata_diown,
  input  logic              ata_iordy,
  input  logic [DW-1:0]     dd_in,
  output logic [DW-1:0]     dd_out,
  output logic              dd_oe,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  output logic              timeout_flag
);
  localparam int TMAX = (1 << PIO_TW) - 1;
  localparam int AW   = $clog2(((ACT_MAX > TMAX) ? ACT_MAX : TMAX) + 1);

  pio_state_e        state;
  pio_tset_t         tset, tset_q;
  logic [PIO_TW-1:0] cnt, rec_len;
  logic [AW-1:0]     acnt;
  logic [HOLD_W-1:0] hold_q, hcnt;
  logic              wr_q, ien_q;
  logic [DA_W-1:0]   dec_da;
  logic              dec_cs1n, dec_cs0n;
  logic              act_done;

  pata_timing_sel u_tsel (
    .reg8(req_reg8), .act8(t_act8), .rec8(t_rec8), .cyc8(t_cyc8),
    .act16(t_act16), .rec16(t_rec16), .cyc16(t_cyc16), .tset(tset)
  );

  pata_sel_decode #(.DA_W(DA_W)) u_dec (
    .sel(req_sel), .da(dec_da), .cs1n(dec_cs1n), .cs0n(dec_cs0n)
  );

  pata_recov_calc #(.TW(PIO_TW), .AW(AW)) u_rec (
    .rec(tset_q.rec), .cyc(tset_q.cyc), .act_len(acnt), .rec_len(rec_len)
  );

  // Active phase may end once the programmed time is spent and the device is
  // ready, monitoring is off, or the cap is reached.
  assign act_done = (acnt >= AW'(tset_q.act)) &&
                    (!ien_q || ata_iordy || (acnt >= AW'(ACT_MAX)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ata_cs0n     <= 1'b1;
      ata_cs1n     <= 1'b1;
      ata_da       <= '0;
      ata_diorn    <= 1'b1;
      ata_diown    <= 1'b1;
      dd_out       <= '0;
      dd_oe        <= 1'b0;
      ack          <= 1'b0;
      rdata        <= '0;
      timeout_flag <= 1'b0;
      cnt          <= '0;
      acnt         <= '0;
      hcnt         <= '0;
      hold_q       <= '0;
      wr_q         <= 1'b0;
      ien_q        <= 1'b0;
      tset_q       <= '0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            wr_q     <= req_wr;
            ien_q    <= iordy_en;
            tset_q   <= tset;
            hold_q   <= wr_hold;
            dd_out   <= req_wdata;
            ata_da   <= dec_da;
            ata_cs1n <= dec_cs1n;
            ata_cs0n <= dec_cs0n;
            cnt      <= at_least_one(t_setup) - PIO_TW'(1);
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_ACT;
            acnt  <= AW'(1);
            if (wr_q) begin
              ata_diown <= 1'b0;
              dd_oe     <= 1'b1;
            end else begin
              ata_diorn <= 1'b0;
            end
          end else begin
            cnt <= cnt - PIO_TW'(1);
          end
        end
        ST_ACT: begin
          if (act_done) begin
            ata_diorn <= 1'b1;
            ata_diown <= 1'b1;
            state     <= ST_REC;
            cnt       <= rec_len - PIO_TW'(1);
            if (!wr_q) rdata <= dd_in;
            dd_oe <= wr_q && (hold_q != '0);
            hcnt  <= hold_q - HOLD_W'(1);
            if (ien_q && !ata_iordy) timeout_flag <= 1'b1;
          end else begin
            acnt <= acnt + AW'(1);
          end
        end
        ST_REC: begin
          if (hcnt == '0) dd_oe <= 1'b0;
          else            hcnt  <= hcnt - HOLD_W'(1);
          if (cnt == '0) begin
            state    <= ST_IDLE;
            ata_cs0n <= 1'b1;
            ata_cs1n <= 1'b1;
            ata_da   <= '0;
            dd_oe    <= 1'b0;
            ack      <= 1'b1;
          end else begin
            cnt <= cnt - PIO_TW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pata_pio_seq_chk.sv
module pata_pio_seq_chk #(
  parameter int ACT_MAX = 257
) (
  input logic       clk,
  input logic       rst,
  input logic       ata_cs0n,
  input logic       ata_cs1n,
  input logic [2:0] ata_da,
  input logic       ata_diorn,
  input logic       ata_diown,
  input logic       dd_oe,
  input logic       ack,
  input logic       timeout_flag
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!ata_diorn || !ata_diown) low_cnt <= low_cnt + 16'd1;
    else low_cnt <= '0;
  end

  a_r1_idle_strobes: assert property (@(posedge clk) disable iff (rst)
    (ata_cs0n && ata_cs1n) |-> (ata_diorn && ata_diown && !dd_oe));

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!ata_diorn && !ata_diown));

  a_r2_sel_stable: assert property (@(posedge clk) disable iff (rst)
    (!ata_diorn || !ata_diown) |-> $stable({ata_da, ata_cs1n, ata_cs0n}));

  a_r5_active_cap: assert property (@(posedge clk) disable iff (rst)
    (!ata_diorn || !ata_diown) |-> (low_cnt < 16'(ACT_MAX)));

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    timeout_flag |=> timeout_flag);

  a_r9_oe_write: assert property (@(posedge clk) disable iff (rst)
    !ata_diown |-> dd_oe);

  a_r9_no_oe_read: assert property (@(posedge clk) disable iff (rst)
    !ata_diorn |-> !dd_oe);

  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r10_ack_idle: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ata_cs0n && ata_cs1n && ata_diorn && ata_diown));
endmodule

bind pata_pio_seq pata_pio_seq_chk #(.ACT_MAX(ACT_MAX)) u_chk (
  .clk(clk), .rst(rst), .ata_cs0n(ata_cs0n), .ata_cs1n(ata_cs1n),
  .ata_da(ata_da), .ata_diorn(ata_diorn), .ata_diown(ata_diown),
  .dd_oe(dd_oe), .ack(ack), .timeout_flag(timeout_flag)
);

// File: tb/pata_pio_seq_tb.sv
`timescale 1ns/1ps
module pata_pio_seq_tb;
  localparam int ACT_MAX = 257;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, req = 1'b0, req_wr = 1'b0, req_reg8 = 1'b0, iordy_en = 1'b0;
  logic [4:0]  req_sel = '0;
  logic [15:0] req_wdata = '0, dd_in = '0;
  logic [7:0]  t_setup = 8'd1, t_act8 = 8'd1, t_rec8 = 8'd1, t_cyc8 = 8'd1;
  logic [7:0]  t_act16 = 8'd1, t_rec16 = 8'd1, t_cyc16 = 8'd1;
  logic [1:0]  wr_hold = '0;
  logic        ata_iordy = 1'b1;
  logic        ata_cs0n, ata_cs1n, ata_diorn, ata_diown, dd_oe, ack, timeout_flag;
  logic [2:0]  ata_da;
  logic [15:0] dd_out, rdata;

  pata_pio_seq #(.ACT_MAX(ACT_MAX)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_reg8(req_reg8),
    .req_sel(req_sel), .req_wdata(req_wdata), .iordy_en(iordy_en),
    .t_setup(t_setup), .t_act8(t_act8), .t_rec8(t_rec8), .t_cyc8(t_cyc8),
    .t_act16(t_act16), .t_rec16(t_rec16), .t_cyc16(t_cyc16), .wr_hold(wr_hold),
    .ata_cs0n(ata_cs0n), .ata_cs1n(ata_cs1n), .ata_da(ata_da),
    .ata_diorn(ata_diorn), .ata_diown(ata_diown), .ata_iordy(ata_iordy),
    .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe), .ack(ack), .rdata(rdata),
    .timeout_flag(timeout_flag)
  );

  typedef struct {
    logic [4:0]  sel;
    bit          wr;
    int          s, a, r, h;
    logic [15:0] wd, rd;
    bit          to;
    string       atag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_err = 0;
  bit   done = 0, to_sticky = 0;
  logic [15:0] rd_val = '0;
  int   w_low = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  // Device model: read data only valid while DIOR- low; ready held low for
  // the first w_low-1 strobe-low ticks.
  int k_low = 0;
  always @(negedge clk) begin
    if (!ata_diorn || !ata_diown) begin
      k_low = k_low + 1;
      ata_iordy <= (k_low >= w_low);
    end else begin
      k_low = 0;
      ata_iordy <= 1'b1;
    end
    dd_in <= !ata_diorn ? rd_val : 16'hDEAD;
  end

  // Monitor
  bit in_xfer = 0, prev_ack = 0, sel_bad = 0, oe_bad = 0, m_wr = 0;
  int s_c = 0, a_c = 0, r_c = 0, h_c = 0;
  logic [4:0]  m_sel;
  logic [15:0] m_dout;
  always @(negedge clk) begin
    if (!rst) begin
      if (ack) begin
        exp_t e;
        chk(!prev_ack, "R10 ack width", prev_ack, 0);
        chk(ata_cs0n && ata_cs1n, "R10 idle at ack", {ata_cs1n, ata_cs0n}, 3);
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected cycle", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(m_sel == e.sel && !sel_bad, "R2 select", m_sel, e.sel);
          chk(m_wr == e.wr, "R3 strobe direction", m_wr, e.wr);
          chk(s_c == e.s, "R3 setup ticks", s_c, e.s);
          chk(a_c == e.a, e.atag, a_c, e.a);
          chk(r_c == e.r, "R7 recovery ticks", r_c, e.r);
          chk(h_c == e.h, "R9 hold ticks", h_c, e.h);
          chk(!oe_bad, "R9 output enable in active", oe_bad, 0);
          if (e.wr) chk(m_dout == e.wd, "R9 write data", m_dout, e.wd);
          else      chk(rdata == e.rd, "R8 read data", rdata, e.rd);
          chk(timeout_flag == e.to, "R6 timeout flag", timeout_flag, e.to);
        end
        in_xfer = 0;
      end else if (!(ata_cs0n && ata_cs1n)) begin
        if (!in_xfer) begin
          in_xfer = 1; m_sel = {ata_da, ata_cs1n, ata_cs0n};
          s_c = 0; a_c = 0; r_c = 0; h_c = 0; sel_bad = 0; oe_bad = 0;
        end
        if ({ata_da, ata_cs1n, ata_cs0n} != m_sel) sel_bad = 1;
        if (!ata_diorn || !ata_diown) begin
          a_c++; m_wr = !ata_diown; m_dout = dd_out;
          if (!ata_diown && !dd_oe) oe_bad = 1;
          if (!ata_diorn && dd_oe) oe_bad = 1;
        end else if (a_c == 0) s_c++;
        else begin
          r_c++;
          if (dd_oe) h_c++;
        end
      end
      prev_ack = ack;
    end
  end

  function automatic int cl(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // Driver: computes the expectation, pushes it, pulses req at current time.
  task automatic start(input logic [4:0] sel, input bit wr, input bit r8,
                       input logic [15:0] wd, input logic [15:0] rv,
                       input int w, input bit ien);
    exp_t e;
    int A, RC, CY, act, R, hmin;
    A  = cl(r8 ? t_act8 : t_act16);
    RC = cl(r8 ? t_rec8 : t_rec16);
    CY = cl(r8 ? t_cyc8 : t_cyc16);
    act = A;
    if (ien && w > A) act = (w < ACT_MAX) ? w : ACT_MAX;
    if (ien && w > ACT_MAX) to_sticky = 1;
    R = (CY - act > RC) ? CY - act : RC;
    hmin = wr ? ((int'(wr_hold) < R) ? int'(wr_hold) : R) : 0;
    e.sel = sel; e.wr = wr; e.s = cl(t_setup); e.a = act; e.r = R; e.h = hmin;
    e.wd = wd; e.rd = rv; e.to = to_sticky;
    e.atag = ien ? "R5 active ticks with ready" : "R4 active ticks";
    if (ien && w > ACT_MAX) e.atag = "R6 capped active ticks";
    exp_q.push_back(e);
    rd_val = rv; w_low = w;
    req_sel = sel; req_wr = wr; req_reg8 = r8; req_wdata = wd; iordy_en = ien;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_ack();
    while (!ack) @(negedge clk);
  endtask

  task automatic gap();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ata_cs0n && ata_cs1n && ata_diorn && ata_diown, "R1 idle pins",
        {ata_cs0n, ata_cs1n, ata_diorn, ata_diown}, 15);
    chk(!dd_oe && !ack && ata_da == 0, "R1 idle outputs", {dd_oe, ack, ata_da}, 0);
    chk(!timeout_flag, "R1 timeout after reset", timeout_flag, 0);

    t_setup = 2; t_act8 = 3; t_rec8 = 2; t_cyc8 = 10;
    t_act16 = 4; t_rec16 = 3; t_cyc16 = 5; wr_hold = 2;
    start(5'd30, 0, 1, 16'h0, 16'h00A5, 0, 0); wait_ack(); gap();   // status read
    start(5'd2, 1, 0, 16'h1234, 16'h0, 0, 0); wait_ack(); gap();    // data write
    wr_hold = 3;
    start(5'd25, 1, 1, 16'h0055, 16'h0, 0, 0); wait_ack(); gap();   // control write
    wr_hold = 0;
    start(5'd6, 1, 1, 16'h00AA, 16'h0, 0, 0); wait_ack(); gap();    // hold zero
    // zero timings count as one
    t_setup = 0; t_act16 = 0; t_rec16 = 0; t_cyc16 = 0; wr_hold = 3;
    start(5'd2, 0, 0, 16'h0, 16'hBEEF, 0, 0); wait_ack(); gap();
    start(5'd2, 1, 0, 16'hC0DE, 16'h0, 0, 0); wait_ack(); gap();    // hold capped by R
    // ready ignored when monitoring off, early low ignored when on
    t_setup = 1;
    start(5'd10, 0, 1, 16'h0, 16'h0011, 20, 0); wait_ack(); gap();
    start(5'd14, 0, 1, 16'h0, 16'h0022, 2, 1); wait_ack(); gap();
    // ready stretches active past programmed time; recovery from minimum
    start(5'd18, 0, 1, 16'h0, 16'h0033, 12, 1); wait_ack(); gap();
    // back-to-back: new request in the ack tick
    start(5'd30, 0, 1, 16'h0, 16'h0044, 0, 0); wait_ack();
    start(5'd22, 1, 1, 16'h7788, 16'h0, 0, 0); wait_ack(); gap();
    // request while busy is ignored
    start(5'd26, 0, 1, 16'h0, 16'h0066, 0, 0);
    @(negedge clk);
    req_sel = 5'd25; req = 1'b1; @(negedge clk); req = 1'b0;
    wait_ack();
    repeat (4) @(negedge clk);
    chk(ata_cs0n && ata_cs1n, "R10 busy request ignored", {ata_cs1n, ata_cs0n}, 3);
    // ready timeout
    start(5'd30, 0, 1, 16'h0, 16'h0077, 300, 1); wait_ack(); gap();
    start(5'd30, 0, 1, 16'h0, 16'h0088, 0, 1); wait_ack(); gap();   // flag stays
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all cycles completed", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule